// File: doc/BRIEF.md
# Five-Level Page Table Walker

This block turns a 64-bit virtual address into a 50-bit physical address. It walks a radix page table five levels deep, with 4 KiB base pages. A caller hands over the virtual address, the kind of access (load, store or fetch), a flag that marks a user-mode access and the physical page number of the root table. The walker then reads one 64-bit page-table entry per step over a simple read port. Each request is a single-cycle strobe with an address, and its response is a single-cycle strobe with data. When the walk ends, the block emits a one-cycle completion pulse. The pulse carries either the physical address or one of two fault flags: an access fault for a badly formed virtual address, or a page fault for anything the table rejects.

A leaf may sit at any of the five levels, so one walk can map a 4 KiB page or a 2 MiB, 1 GiB, 512 GiB or 256 TiB region. The accessed and dirty bits are never written by hardware. A leaf whose bits do not allow the access faults, and software sets the bits and retries. The walker holds one translation at a time and accepts the next only after the completion pulse.

Top module: `ptw_five_level`

## Requirements
- R1: If bits 63..57 of the virtual address are not all equal to bit 56, the walk completes with the access-fault flag set, the page-fault flag clear, and no memory request. An address whose upper bits do match is walked normally, including one with bit 56 set.
- R2: Each step reads the entry at physical address (table PPN << 12) + 8 * index. The walk starts at level 4 with the root PPN. The index at level i is virtual-address bits [12+9i+8 : 12+9i]. After a pointer, the next table PPN is PTE bits 47..10.
- R3: A leaf at level 0 gives a physical address made of PTE bits 47..10 above the untranslated 12-bit page offset, with both fault flags clear.
- R4: A leaf at level i > 0 maps a superpage. The physical-address PPN slices below i come from the matching virtual-address slices, and the rest come from the PTE. The 2-bit top slice comes from PTE bits 47..46.
- R5: A leaf at level i > 0 whose PTE PPN slices below i are not all zero raises a page fault.
- R6: An entry with V (bit 0) clear, or with R (bit 1) clear and W (bit 2) set, raises a page fault.
- R7: An entry with R, W and X (bit 3) all clear is a pointer. Meeting a pointer at level 0 raises a page fault after the fifth read.
- R8: Access kind code 0 is a load and needs R. Code 1 is a store and needs W. Code 2 is a fetch and needs X. A missing permission raises a page fault.
- R9: A user access needs U (bit 4) set, and a supervisor access to a leaf with U set faults. A mismatch raises a page fault.
- R10: A leaf with A (bit 6) clear faults for every access kind, and a leaf with D (bit 7) clear faults for a store. Neither bit is updated by the block.
- R11: PTE bits 9..8 are ignored: changing them leaves the result unchanged.
- R12: A request is taken when reqValid and reqReady are both high, and reqReady stays low until the completion has been signalled. doneValid is a one-cycle pulse. At most one fault flag is set, and a faulted result carries a zero physical address.
- R13: At most one memory read is outstanding. memReqValid lasts one cycle, a response is accepted any number of cycles (at least one) after its request, and a walk makes no more than five reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqVaddr | input | 64 | Virtual address to translate |
| reqKind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| reqUser | input | 1 | Access made in user mode |
| rootPpn | input | 38 | PPN of the root table |
| memReqValid | output | 1 | Read strobe for one page-table entry |
| memReqAddr | output | 50 | Physical byte address of the entry |
| memRspValid | input | 1 | Read data present |
| memRspData | input | 64 | Page-table entry read back |
| doneValid | output | 1 | One-cycle completion pulse |
| donePaddr | output | 50 | Translated physical address (zero on fault) |
| donePageFault | output | 1 | Walk ended in a page fault |
| doneAccessFault | output | 1 | Walk ended in an access fault |

## Verification
The bench aims at the places where a walker goes quietly wrong, which are the superpage boundaries. A leaf at each of levels 1 through 4 must take its lower slices from the virtual address. A design that merges the slices at the wrong level returns a plausible but wrong address, and one that skips the alignment test lets a misaligned superpage through. Sign-extension is tried with both matching and mismatching upper bits, so a design that checks the wrong bit range either faults a valid high address or walks an illegal one. The bench also covers store-without-dirty, user/supervisor mismatch, a pointer at the last level and the reserved-for-software bits. A design that decodes any of these loosely hands back a translation where a page fault is due.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_NONE  = 2'd3
  } accessKind_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } walkState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic captureReq;
    logic descend;
    logic finishLeaf;
    logic finishPageFault;
    logic finishAccessFault;
  } walkStrobes_t;

  // entry flag positions (decoded by the walker, fixed by table format)
  localparam int FLAG_V = 0;
  localparam int FLAG_R = 1;
  localparam int FLAG_W = 2;
  localparam int FLAG_X = 3;
  localparam int FLAG_U = 4;
  localparam int FLAG_A = 6;
  localparam int FLAG_D = 7;
  localparam int PTE_PPN_LSB = 10;

endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int LEVELS       = 5,
  parameter int VPN_BITS     = 9,
  parameter int OFFSET_BITS  = 12,
  parameter int TOP_PPN_BITS = 2,
  parameter int PTE_BYTES_LOG2 = 3,
  localparam int PPN_BITS = TOP_PPN_BITS + VPN_BITS * (LEVELS - 1),
  localparam int PA_BITS  = PPN_BITS + OFFSET_BITS,
  localparam int VA_BITS  = OFFSET_BITS + VPN_BITS * LEVELS,
  localparam int LVL_W    = $clog2(LEVELS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkStrobes_t        strb,
  input  logic [63:0]         reqVaddr,
  input  accessKind_t         reqKind,
  input  logic                reqUser,
  input  logic [PPN_BITS-1:0] rootPpn,
  input  logic [63:0]         memRspData,
  output logic                canonicalOk,
  output logic                pteIsPointer,
  output logic                pteFault,
  output logic [PA_BITS-1:0]  memReqAddr,
  output logic [PA_BITS-1:0]  donePaddr,
  output logic                donePageFault,
  output logic                doneAccessFault
);

  logic [VA_BITS-1:0]  vaddrQ;
  accessKind_t         kindQ;
  logic                userQ;
  logic [PPN_BITS-1:0] ppnQ;
  logic [LVL_W-1:0]    levelQ;

  // upper address bits must replicate the top translated bit
  logic [64-VA_BITS:0] upperBits;
  assign upperBits   = reqVaddr[63:VA_BITS-1];
  assign canonicalOk = (&upperBits) || !(|upperBits);

  // index slices of the held virtual address
  logic [VPN_BITS-1:0] vpnField [LEVELS];
  for (genvar g = 0; g < LEVELS; g++) begin : g_vpn
    assign vpnField[g] = vaddrQ[OFFSET_BITS + g*VPN_BITS +: VPN_BITS];
  end

  logic [VPN_BITS-1:0] curVpn;
  assign curVpn = vpnField[levelQ];

  assign memReqAddr = {ppnQ, {OFFSET_BITS{1'b0}}}
                    + (PA_BITS'(curVpn) << PTE_BYTES_LOG2);

  // entry decode
  logic pteV, pteR, pteW, pteX, pteU, pteA, pteD;
  logic [PPN_BITS-1:0] ptePpn;
  assign pteV   = memRspData[FLAG_V];
  assign pteR   = memRspData[FLAG_R];
  assign pteW   = memRspData[FLAG_W];
  assign pteX   = memRspData[FLAG_X];
  assign pteU   = memRspData[FLAG_U];
  assign pteA   = memRspData[FLAG_A];
  assign pteD   = memRspData[FLAG_D];
  assign ptePpn = memRspData[PTE_PPN_LSB +: PPN_BITS];

  logic unusedPteBits;
  assign unusedPteBits = ^{memRspData[63:PTE_PPN_LSB+PPN_BITS],
                           memRspData[PTE_PPN_LSB-1:FLAG_D+1],
                           memRspData[5]};

  // superpage merge and alignment test, one slice per lower level
  logic [LEVELS-2:0]   lowNonZero;
  logic [PPN_BITS-1:0] leafPpn;
  for (genvar g = 0; g < LEVELS - 1; g++) begin : g_slice
    logic belowLeaf;
    assign belowLeaf     = LVL_W'(g) < levelQ;
    assign lowNonZero[g] = belowLeaf && (|ptePpn[g*VPN_BITS +: VPN_BITS]);
    assign leafPpn[g*VPN_BITS +: VPN_BITS] =
      belowLeaf ? vpnField[g] : ptePpn[g*VPN_BITS +: VPN_BITS];
  end
  assign leafPpn[PPN_BITS-1 -: TOP_PPN_BITS] = ptePpn[PPN_BITS-1 -: TOP_PPN_BITS];

  logic permOk, privOk, flagOk, badEncoding, leafFault;
  always_comb begin
    case (kindQ)
      KIND_LOAD:  permOk = pteR;
      KIND_STORE: permOk = pteW;
      KIND_FETCH: permOk = pteX;
      default:    permOk = 1'b0;
    endcase
  end

  assign privOk       = userQ ? pteU : !pteU;
  assign flagOk       = pteA && ((kindQ != KIND_STORE) || pteD);
  assign badEncoding  = !pteV || (!pteR && pteW);
  assign pteIsPointer = pteV && !pteR && !pteW && !pteX;
  assign leafFault    = (|lowNonZero) || !permOk || !privOk || !flagOk;
  assign pteFault     = badEncoding
                      || (pteIsPointer && (levelQ == '0))
                      || (!pteIsPointer && leafFault);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaddrQ          <= '0;
      kindQ           <= KIND_LOAD;
      userQ           <= 1'b0;
      ppnQ            <= '0;
      levelQ          <= '0;
      donePaddr       <= '0;
      donePageFault   <= 1'b0;
      doneAccessFault <= 1'b0;
    end else begin
      if (strb.captureReq) begin
        vaddrQ <= reqVaddr[VA_BITS-1:0];
        kindQ  <= reqKind;
        userQ  <= reqUser;
        ppnQ   <= rootPpn;
        levelQ <= LVL_W'(LEVELS - 1);
      end
      if (strb.descend) begin
        ppnQ   <= ptePpn;
        levelQ <= levelQ - 1'b1;
      end
      if (strb.finishLeaf) begin
        donePaddr       <= {leafPpn, vaddrQ[OFFSET_BITS-1:0]};
        donePageFault   <= 1'b0;
        doneAccessFault <= 1'b0;
      end
      if (strb.finishPageFault) begin
        donePaddr       <= '0;
        donePageFault   <= 1'b1;
        doneAccessFault <= 1'b0;
      end
      if (strb.finishAccessFault) begin
        donePaddr       <= '0;
        donePageFault   <= 1'b0;
        doneAccessFault <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ptw_control.sv
module ptw_control
  import ptw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         canonicalOk,
  input  logic         memRspValid,
  input  logic         pteIsPointer,
  input  logic         pteFault,
  output logic         reqReady,
  output logic         memReqValid,
  output logic         doneValid,
  output walkStrobes_t strb
);

  walkState_t state, nextState;

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.captureReq = 1'b1;
          if (!canonicalOk) begin
            strb.finishAccessFault = 1'b1;
            nextState = ST_DONE;
          end else begin
            nextState = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: nextState = ST_WAIT;
      ST_WAIT: begin
        if (memRspValid) begin
          if (pteFault) begin
            strb.finishPageFault = 1'b1;
            nextState = ST_DONE;
          end else if (pteIsPointer) begin
            strb.descend = 1'b1;
            nextState = ST_ISSUE;
          end else begin
            strb.finishLeaf = 1'b1;
            nextState = ST_DONE;
          end
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_ISSUE);
  assign doneValid   = (state == ST_DONE);

endmodule

// File: rtl/ptw_five_level.sv
module ptw_five_level
  import ptw_pkg::*;
#(
  parameter int LEVELS       = 5,
  parameter int VPN_BITS     = 9,
  parameter int OFFSET_BITS  = 12,
  parameter int TOP_PPN_BITS = 2,
  localparam int PPN_BITS = TOP_PPN_BITS + VPN_BITS * (LEVELS - 1),
  localparam int PA_BITS  = PPN_BITS + OFFSET_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [63:0]         reqVaddr,
  input  logic [1:0]          reqKind,
  input  logic                reqUser,
  input  logic [PPN_BITS-1:0] rootPpn,
  output logic                memReqValid,
  output logic [PA_BITS-1:0]  memReqAddr,
  input  logic                memRspValid,
  input  logic [63:0]         memRspData,
  output logic                doneValid,
  output logic [PA_BITS-1:0]  donePaddr,
  output logic                donePageFault,
  output logic                doneAccessFault
);

  walkStrobes_t strb;
  logic canonicalOk, pteIsPointer, pteFault;

  ptw_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .canonicalOk  (canonicalOk),
    .memRspValid  (memRspValid),
    .pteIsPointer (pteIsPointer),
    .pteFault     (pteFault),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .doneValid    (doneValid),
    .strb         (strb)
  );

  ptw_datapath #(
    .LEVELS       (LEVELS),
    .VPN_BITS     (VPN_BITS),
    .OFFSET_BITS  (OFFSET_BITS),
    .TOP_PPN_BITS (TOP_PPN_BITS)
  ) u_datapath (
    .clk             (clk),
    .rstN            (rstN),
    .strb            (strb),
    .reqVaddr        (reqVaddr),
    .reqKind         (accessKind_t'(reqKind)),
    .reqUser         (reqUser),
    .rootPpn         (rootPpn),
    .memRspData      (memRspData),
    .canonicalOk     (canonicalOk),
    .pteIsPointer    (pteIsPointer),
    .pteFault        (pteFault),
    .memReqAddr      (memReqAddr),
    .donePaddr       (donePaddr),
    .donePageFault   (donePageFault),
    .doneAccessFault (doneAccessFault)
  );

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int LEVELS      = 5,
  parameter int OFFSET_BITS = 12,
  parameter int PA_BITS     = 50
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic                   reqReady,
  input logic [OFFSET_BITS-1:0] reqOffset,
  input logic                   memReqValid,
  input logic                   doneValid,
  input logic [PA_BITS-1:0]     donePaddr,
  input logic                   donePageFault,
  input logic                   doneAccessFault
);

  logic [7:0]             readsSinceAccept;
  logic [OFFSET_BITS-1:0] offQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readsSinceAccept <= '0;
      offQ             <= '0;
    end else if (reqValid && reqReady) begin
      readsSinceAccept <= '0;
      offQ             <= reqOffset;
    end else if (memReqValid) begin
      readsSinceAccept <= readsSinceAccept + 1'b1;
    end
  end

  // R1
  af_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneAccessFault) |-> (readsSinceAccept == '0));

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !donePageFault && !doneAccessFault)
      |-> (donePaddr[OFFSET_BITS-1:0] == offQ));

  // R12
  one_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !(donePageFault && doneAccessFault));

  // R12
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && (donePageFault || doneAccessFault)) |-> (donePaddr == '0));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R12
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || doneValid) |-> !reqReady);

  // R13
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R13
  read_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (readsSinceAccept < 8'(LEVELS)));

endmodule

bind ptw_five_level ptw_checker #(
  .LEVELS      (LEVELS),
  .OFFSET_BITS (OFFSET_BITS),
  .PA_BITS     (PA_BITS)
) u_checker (
  .clk             (clk),
  .rstN            (rstN),
  .reqValid        (reqValid),
  .reqReady        (reqReady),
  .reqOffset       (reqVaddr[OFFSET_BITS-1:0]),
  .memReqValid     (memReqValid),
  .doneValid       (doneValid),
  .donePaddr       (donePaddr),
  .donePageFault   (donePageFault),
  .doneAccessFault (doneAccessFault)
);

// File: tb/ptw_five_level_test.sv
module ptw_five_level_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_FE = 2'd2;
  localparam logic [37:0] ROOT = 38'h100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqVaddr = '0;
  logic [1:0]  reqKind = '0;
  logic        reqUser = 1'b0;
  logic [37:0] rootPpn = ROOT;
  logic        memReqValid;
  logic [49:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        doneValid;
  logic [49:0] donePaddr;
  logic        donePageFault;
  logic        doneAccessFault;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_five_level uut (.*);

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [63:0] memModel [logic [49:0]];
  int          rspDelay = 1;
  int          readCount = 0;
  logic [49:0] addrLog [8];

  function automatic logic [49:0] pteAddr(input logic [37:0] ppn, input logic [8:0] idx);
    return {ppn, idx, 3'b000};
  endfunction

  function automatic logic [63:0] mkPte(input logic [37:0] ppn, input logic [7:0] flags,
                                        input logic [1:0] rsw);
    return {16'h0000, ppn, rsw, flags};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: one read at a time, response rspDelay cycles later
  initial begin : responder
    logic [49:0] a;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (memReqValid) begin
        a = memReqAddr;
        if (readCount < 8) addrLog[readCount] = a;
        readCount++;
        repeat (rspDelay) @(negedge clk);
        memRspData  = memModel.exists(a) ? memModel[a] : 64'h0;
        memRspValid = 1'b1;
      end
    end
  end

  typedef struct packed {
    logic [8:0]  v4, v3, v2, v1, v0;
    logic [11:0] off;
    logic [6:0]  upFlip;
    logic [1:0]  kind;
    logic        user;
    logic [49:0] expPa;
    logic        expPf;
    logic        expAf;
    logic [3:0]  expReads;
    logic [3:0]  tag;
  } vec_t;

  localparam int NVEC = 25;
  localparam vec_t VECS [NVEC] = '{
    // R3 4 KiB load
    '{9'h0, 9'h0, 9'h0, 9'h0, 9'h1, 12'hABC, 7'h0, K_LD, 1'b0, 50'h12345ABC, 1'b0, 1'b0, 4'd5, 4'd3},
    // R8 fetch
    '{9'h0, 9'h0, 9'h0, 9'h0, 9'h1, 12'h004, 7'h0, K_FE, 1'b0, 50'h12345004, 1'b0, 1'b0, 4'd5, 4'd8},
    // R8 store
    '{9'h0, 9'h0, 9'h0, 9'h0, 9'h1, 12'hFFF, 7'h0, K_ST, 1'b0, 50'h12345FFF, 1'b0, 1'b0, 4'd5, 4'd8},
    // R10 load on D=0 page succeeds
    '{9'h0, 9'h0, 9'h0, 9'h0, 9'h2, 12'h010, 7'h0, K_LD, 1'b0, 50'h22222010, 1'b0, 1'b0, 4'd5, 4'd10},
    // R10 store on D=0 faults
    '{9'h0, 9'h0, 9'h0, 9'h0, 9'h2, 12'h010, 7'h0, K_ST, 1'b0, 50'h0, 1'b1, 1'b0, 4'd5, 4'd10},
    // R10 A=0 faults
    '{9'h0, 9'h0, 9'h0, 9'h0, 9'h3, 12'h000, 7'h0, K_LD, 1'b0, 50'h0, 1'b1, 1'b0, 4'd5, 4'd10},
    // R7 pointer at level 0
    '{9'h0, 9'h0, 9'h0, 9'h0, 9'h4, 12'h000, 7'h0, K_LD, 1'b0, 50'h0, 1'b1, 1'b0, 4'd5, 4'd7},
    // R9 user on U page
    '{9'h0, 9'h0, 9'h0, 9'h0, 9'h5, 12'h000, 7'h0, K_LD, 1'b1, 50'h33333000, 1'b0, 1'b0, 4'd5, 4'd9},
    // R9 supervisor on U page
    '{9'h0, 9'h0, 9'h0, 9'h0, 9'h5, 12'h000, 7'h0, K_LD, 1'b0, 50'h0, 1'b1, 1'b0, 4'd5, 4'd9},
    // R9 user on supervisor page
    '{9'h0, 9'h0, 9'h0, 9'h0, 9'h1, 12'h000, 7'h0, K_LD, 1'b1, 50'h0, 1'b1, 1'b0, 4'd5, 4'd9},
    // R6 V=0 leaf-looking entry
    '{9'h0, 9'h0, 9'h0, 9'h0, 9'h6, 12'h000, 7'h0, K_LD, 1'b0, 50'h0, 1'b1, 1'b0, 4'd5, 4'd6},
    // R4 2 MiB load
    '{9'h0, 9'h0, 9'h0, 9'h2, 9'h155, 12'h321, 7'h0, K_LD, 1'b0, 50'h3555321, 1'b0, 1'b0, 4'd4, 4'd4},
    // R4 2 MiB store
    '{9'h0, 9'h0, 9'h0, 9'h2, 9'h155, 12'h000, 7'h0, K_ST, 1'b0, 50'h3555000, 1'b0, 1'b0, 4'd4, 4'd4},
    // R6 R=0 W=1
    '{9'h0, 9'h0, 9'h0, 9'h3, 9'h0, 12'h000, 7'h0, K_LD, 1'b0, 50'h0, 1'b1, 1'b0, 4'd4, 4'd6},
    // R4 1 GiB user fetch
    '{9'h0, 9'h0, 9'h1, 9'h0AA, 9'h0F0, 12'h123, 7'h0, K_FE, 1'b1, 50'h1D54F0123, 1'b0, 1'b0, 4'd3, 4'd4},
    // R8 store to read/execute page
    '{9'h0, 9'h0, 9'h1, 9'h0AA, 9'h0F0, 12'h123, 7'h0, K_ST, 1'b1, 50'h0, 1'b1, 1'b0, 4'd3, 4'd8},
    // R4 512 GiB load
    '{9'h0, 9'h5, 9'h1FF, 9'h001, 9'h002, 12'h0CD, 7'h0, K_LD, 1'b0, 50'h103FFC02020CD, 1'b0, 1'b0, 4'd2, 4'd4},
    // R4 256 TiB fetch
    '{9'h1, 9'h123, 9'h045, 9'h067, 9'h089, 12'hEEE, 7'h0, K_FE, 1'b0, 50'h291914CE89EEE, 1'b0, 1'b0, 4'd1, 4'd4},
    // R5 misaligned 256 TiB
    '{9'h2, 9'h0, 9'h0, 9'h0, 9'h0, 12'h000, 7'h0, K_LD, 1'b0, 50'h0, 1'b1, 1'b0, 4'd1, 4'd5},
    // R6 pointer into empty table
    '{9'h3, 9'h0, 9'h0, 9'h0, 9'h0, 12'h000, 7'h0, K_LD, 1'b0, 50'h0, 1'b1, 1'b0, 4'd2, 4'd6},
    // R1 bit 63 differs
    '{9'h0, 9'h0, 9'h0, 9'h0, 9'h1, 12'h000, 7'h40, K_LD, 1'b0, 50'h0, 1'b0, 1'b1, 4'd0, 4'd1},
    // R1 high canonical address is walked
    '{9'h1FF, 9'h0, 9'h0, 9'h0, 9'h0, 12'h000, 7'h0, K_LD, 1'b0, 50'h0, 1'b1, 1'b0, 4'd1, 4'd1},
    // R1 bit 57 differs
    '{9'h1FF, 9'h0, 9'h0, 9'h0, 9'h0, 12'h000, 7'h01, K_LD, 1'b0, 50'h0, 1'b0, 1'b1, 4'd0, 4'd1},
    // R9 supervisor fetch from 1 GiB user page
    '{9'h0, 9'h0, 9'h1, 9'h0AA, 9'h0F0, 12'h123, 7'h0, K_FE, 1'b0, 50'h0, 1'b1, 1'b0, 4'd3, 4'd9},
    // R5 misaligned 2 MiB
    '{9'h0, 9'h0, 9'h0, 9'h4, 9'h0, 12'h000, 7'h0, K_LD, 1'b0, 50'h0, 1'b1, 1'b0, 4'd4, 4'd5}
  };

  task automatic runWalk(input vec_t v, input string tag);
    int guard;
    readCount = 0;
    @(negedge clk);
    reqVaddr = {({7{v.v4[8]}} ^ v.upFlip), v.v4, v.v3, v.v2, v.v1, v.v0, v.off};
    reqKind  = v.kind;
    reqUser  = v.user;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    // R12: no new request accepted while the walk is in progress
    check(reqReady == 1'b0, {tag, " R12 busy"}, 64'(reqReady), 64'h0);
    guard = 0;
    while (!doneValid && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(doneValid == 1'b1, {tag, " R12 done"}, 64'(doneValid), 64'h1);
    check(donePaddr == v.expPa, {tag, " paddr"}, 64'(donePaddr), 64'(v.expPa));
    check(donePageFault == v.expPf, {tag, " page fault"}, 64'(donePageFault), 64'(v.expPf));
    check(doneAccessFault == v.expAf, {tag, " access fault"}, 64'(doneAccessFault), 64'(v.expAf));
    check(readCount == int'(v.expReads), {tag, " R13 reads"}, 64'(readCount), 64'(v.expReads));
    @(negedge clk);
    check(doneValid == 1'b0 && reqReady == 1'b1, {tag, " R12 pulse"},
          64'({doneValid, reqReady}), 64'h1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    vec_t v;
    // level 4 (root)
    memModel[pteAddr(ROOT, 9'h000)] = mkPte(38'h101, 8'h01, 2'b00);
    memModel[pteAddr(ROOT, 9'h001)] = mkPte(38'h2000000000, 8'hCF, 2'b00);
    memModel[pteAddr(ROOT, 9'h002)] = mkPte(38'h2000000001, 8'hCF, 2'b00);
    memModel[pteAddr(ROOT, 9'h003)] = mkPte(38'h105, 8'h01, 2'b00);
    // level 3
    memModel[pteAddr(38'h101, 9'h000)] = mkPte(38'h102, 8'h01, 2'b00);
    memModel[pteAddr(38'h101, 9'h005)] = mkPte(38'h1038000000, 8'hCF, 2'b00);
    // level 2
    memModel[pteAddr(38'h102, 9'h000)] = mkPte(38'h103, 8'h01, 2'b00);
    memModel[pteAddr(38'h102, 9'h001)] = mkPte(38'h1C0000, 8'h5B, 2'b00);
    // level 1
    memModel[pteAddr(38'h103, 9'h000)] = mkPte(38'h104, 8'h01, 2'b00);
    memModel[pteAddr(38'h103, 9'h002)] = mkPte(38'h3400, 8'hC7, 2'b11);
    memModel[pteAddr(38'h103, 9'h003)] = mkPte(38'h3600, 8'hC5, 2'b00);
    memModel[pteAddr(38'h103, 9'h004)] = mkPte(38'h3401, 8'hC7, 2'b00);
    // level 0
    memModel[pteAddr(38'h104, 9'h001)] = mkPte(38'h12345, 8'hCF, 2'b11);
    memModel[pteAddr(38'h104, 9'h002)] = mkPte(38'h22222, 8'h47, 2'b00);
    memModel[pteAddr(38'h104, 9'h003)] = mkPte(38'h22223, 8'h03, 2'b00);
    memModel[pteAddr(38'h104, 9'h004)] = mkPte(38'h106, 8'h01, 2'b00);
    memModel[pteAddr(38'h104, 9'h005)] = mkPte(38'h33333, 8'hD7, 2'b00);
    memModel[pteAddr(38'h104, 9'h006)] = mkPte(38'h44444, 8'hCE, 2'b00);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(reqReady == 1'b1, "R12 reset ready", 64'(reqReady), 64'h1);
    check(doneValid == 1'b0, "R12 reset done", 64'(doneValid), 64'h0);
    check(memReqValid == 1'b0, "R13 reset memreq", 64'(memReqValid), 64'h0);

    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      rspDelay = (i % 3) + 1;
      runWalk(v, $sformatf("vec%0d R%0d", i, v.tag));
    end

    // R2: entry address sequence for a full-depth walk
    rspDelay = 2;
    runWalk(VECS[0], "R2 seq");
    check(addrLog[0] == pteAddr(ROOT, 9'h000), "R2 level4 addr", 64'(addrLog[0]),
          64'(pteAddr(ROOT, 9'h000)));
    check(addrLog[1] == pteAddr(38'h101, 9'h000), "R2 level3 addr", 64'(addrLog[1]),
          64'(pteAddr(38'h101, 9'h000)));
    check(addrLog[2] == pteAddr(38'h102, 9'h000), "R2 level2 addr", 64'(addrLog[2]),
          64'(pteAddr(38'h102, 9'h000)));
    check(addrLog[3] == pteAddr(38'h103, 9'h000), "R2 level1 addr", 64'(addrLog[3]),
          64'(pteAddr(38'h103, 9'h000)));
    check(addrLog[4] == pteAddr(38'h104, 9'h001), "R2 level0 addr", 64'(addrLog[4]),
          64'(pteAddr(38'h104, 9'h001)));

    // R13: long response latency
    rspDelay = 9;
    runWalk(VECS[11], "R13 slow memory");

    // R11: clearing the software bits leaves both results unchanged
    rspDelay = 1;
    memModel[pteAddr(38'h104, 9'h001)] = mkPte(38'h12345, 8'hCF, 2'b00);
    memModel[pteAddr(38'h103, 9'h002)] = mkPte(38'h3400, 8'hC7, 2'b00);
    runWalk(VECS[0], "R11 rsw 4k");
    runWalk(VECS[11], "R11 rsw 2m");
    memModel[pteAddr(38'h104, 9'h001)] = mkPte(38'h12345, 8'hCF, 2'b10);
    runWalk(VECS[2], "R11 rsw partial");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule